// File: doc/BRIEF.md
# Frame-Synced Parallel Capture and Transmit Engine

This block is a parallel data port clocked by the external port clock. It connects to data converters and simple video sources or sinks. A burst is a programmed wait followed by a fixed number of data words. In input mode an external frame sync starts each burst. In frame-capture mode the engine generates its own line and frame syncs and samples the bus. In output mode it drives words taken from an input stream onto the bus, together with up to three sync outputs. The bus is half-duplex, so at any moment it either receives or drives.

Captured words leave on a valid/ready stream. `m_data` is held stable while `m_valid` is high and `m_ready` is low. One word of buffering exists. A sample that arrives while that word is still unaccepted is dropped, and `err_ovf` latches. Words to transmit arrive on a second valid/ready stream. The engine raises `s_ready` only while it is in the data phase of an output burst. A word moves only on a cycle in which both `s_valid` and `s_ready` are high. If the source stalls, the burst simply waits. Configuration inputs are expected to change only while no burst is running.

Mode codes on `cfg_mode`: 0 disabled, 1 input, 2 frame capture, 3 output. The effective data width comes from `cfg_width`. The value 8 gives 8 bits, values 10 to 16 give that many bits, and any other value gives 16.

Top module: `pport_engine`

## Requirements
- R1: After reset, `m_valid`, `s_ready`, `pd_oe`, `fs1_out`, `fs2_out`, `fs3_out`, `err_sync` and `err_ovf` are all 0.
- R2: In input mode with `en` high and no burst running, a rising edge on `fs1_in` starts a burst. Let E be the clock edge at which `fs1_in` is first sampled high. The first data sample is taken at edge E+1+`cfg_delay`, and one sample follows at each later edge.
- R3: An input-side burst takes exactly `cfg_count` samples, or one sample when `cfg_count` is 0, and then returns to idle.
- R4: Words on `m_data` and `pd_out` have every bit at or above the effective width cleared. The effective width is 8 for `cfg_width`=8, equal to `cfg_width` for values 10 to 16, and 16 otherwise.
- R5: In frame-capture mode with `en` high, bursts start back to back, one every `cfg_delay`+`cfg_count`+1 cycles. Each burst start gives a one-cycle pulse on `fs1_out`. `fs2_out` pulses together with `fs1_out` on the first line of each frame of `cfg_lines` lines. The first line after `en` rises is line 0. Data is sampled from `pd_in` with the R2 timing, counted from the edge that starts the burst.
- R6: In output mode, once the wait ends, the burst accepts exactly `cfg_count` words from the input stream, then ends. Each accepted word appears on `pd_out` in the cycle after it is accepted and stays there until the next accepted word.
- R7: In output mode, `cfg_nsync` sets how many sync outputs are used. With `cfg_nsync` at 1 or more, `fs1_out` pulses at each burst start. With `cfg_nsync` at 2 or more, `fs2_out` pulses on the first line of each frame. With `cfg_nsync`=3, `fs3_out` pulses in the cycle after each accepted word. Outputs above the selected number stay low.
- R8: `pd_oe` is high in exactly the cycles that follow a cycle in which an output-mode burst was in its data phase (`s_ready` high). It is never high in input or frame-capture mode.
- R9: A rising edge on `fs1_in` during an input-mode burst does not restart or extend the burst, and it sets `err_sync`, which stays set until reset.
- R10: While `m_valid` is high and `m_ready` is low, `m_data` holds. A sample taken in that state is dropped and sets `err_ovf`, which stays set until reset.
- R11: With `en` low no new burst starts. With `cfg_mode`=0 the engine never starts a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Allows new bursts to start |
| cfg_mode | input | 2 | 0 off, 1 input, 2 frame capture, 3 output |
| cfg_width | input | 5 | Data width code |
| cfg_delay | input | DLY_W (8) | Cycles between sync and first data |
| cfg_count | input | CNT_W (12) | Words per burst |
| cfg_lines | input | LINE_W (10) | Lines per frame for the frame sync |
| cfg_nsync | input | 2 | Number of sync outputs used in output mode |
| fs1_in | input | 1 | External frame sync (input mode) |
| fs1_out | output | 1 | Line sync pulse |
| fs2_out | output | 1 | Frame sync pulse |
| fs3_out | output | 1 | Per-word strobe in output mode |
| pd_in | input | DW (16) | Parallel data from the bus |
| pd_out | output | DW (16) | Parallel data to the bus |
| pd_oe | output | 1 | Bus drive enable |
| m_valid | output | 1 | Captured word valid |
| m_ready | input | 1 | Consumer accepts captured word |
| m_data | output | DW (16) | Captured word |
| s_valid | input | 1 | Word to transmit valid |
| s_ready | output | 1 | Engine accepts word to transmit |
| s_data | input | DW (16) | Word to transmit |
| err_sync | output | 1 | Sticky: sync arrived during a burst |
| err_ovf | output | 1 | Sticky: captured sample dropped |

## Verification
The hardest situation to reach from the ports is a second frame-sync edge that lands inside the programmed wait, before any data has been taken. The bench places it by counting port-clock cycles from the first edge. It then confirms that the sample count and the sample alignment still follow the first edge and that `err_sync` latches. A related case is a sample arriving while the one-word output buffer is full. The bench reaches it by holding `m_ready` low through a whole burst, then checking that the first word survives unchanged and that the rest are dropped.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_IN   = 2'd1,
    MODE_FCAP = 2'd2,
    MODE_OUT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } state_e;

  // Legal widths are 8 and 10..16; anything else falls back to 16.
  function automatic logic [31:0] width_mask(input logic [4:0] w);
    int eff;
    if (w == 5'd8)                       eff = 8;
    else if (w >= 5'd10 && w <= 5'd16)   eff = int'(w);
    else                                 eff = 16;
    return (32'h1 << eff) - 32'h1;
  endfunction

endpackage

// File: rtl/pport_seq.sv
module pport_seq
  import pport_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  mode_e             mode,
  input  logic [1:0]        nsync,
  input  logic              fs1_in,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              adv,
  output logic              data_phase,
  output logic              fs1_out,
  output logic              fs2_out,
  output logic              sync_err
);

  state_e            st;
  logic              fs_prev;
  logic [DLY_W-1:0]  dcnt;
  logic [CNT_W-1:0]  scnt;
  logic [LINE_W-1:0] line;

  logic              master, fs_edge, start, last_line;
  logic [CNT_W-1:0]  last_idx;

  assign master    = (mode == MODE_FCAP) || (mode == MODE_OUT);
  assign fs_edge   = fs1_in && !fs_prev;
  assign start     = en && (st == ST_IDLE) &&
                     (((mode == MODE_IN) && fs_edge) || master);
  assign last_idx  = (cfg_count == '0) ? '0 : cfg_count - 1'b1;
  assign last_line = (cfg_lines == '0) || (line == cfg_lines - 1'b1);
  assign data_phase = (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      fs_prev  <= 1'b0;
      dcnt     <= '0;
      scnt     <= '0;
      line     <= '0;
      fs1_out  <= 1'b0;
      fs2_out  <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      fs_prev <= fs1_in;
      unique case (st)
        ST_IDLE: if (start) begin
          scnt <= '0;
          if (cfg_delay == '0) st <= ST_DATA;
          else begin
            st   <= ST_WAIT;
            dcnt <= cfg_delay - 1'b1;
          end
        end
        ST_WAIT: if (dcnt == '0) st <= ST_DATA;
                 else            dcnt <= dcnt - 1'b1;
        ST_DATA: if (adv) begin
          if (scnt == last_idx) st <= ST_IDLE;
          else                  scnt <= scnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase

      if (!en || !master)  line <= '0;
      else if (start)      line <= last_line ? '0 : line + 1'b1;

      fs1_out <= start && ((mode == MODE_FCAP) ||
                           ((mode == MODE_OUT) && (nsync >= 2'd1)));
      fs2_out <= start && (line == '0) &&
                 ((mode == MODE_FCAP) || ((mode == MODE_OUT) && (nsync >= 2'd2)));

      if (en && (mode == MODE_IN) && fs_edge && (st != ST_IDLE))
        sync_err <= 1'b1;
    end
  end

  p_fs2_with_fs1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fs2_out |-> fs1_out);
  p_fs1_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fs1_out |=> !fs1_out);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);
  p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && st == ST_IDLE) |=> (st == ST_IDLE));

endmodule

// File: rtl/pport_rx.sv
module pport_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [DW-1:0] pd_in,
  input  logic [DW-1:0] mask,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          ovf
);

  logic load;
  assign load = sample && (!m_valid || m_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      ovf     <= 1'b0;
    end else begin
      if (load) begin
        m_valid <= 1'b1;
        m_data  <= pd_in & mask;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
      if (sample && m_valid && !m_ready) ovf <= 1'b1;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_rx_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((m_data & ~$past(mask)) == '0));

endmodule

// File: rtl/pport_tx.sv
module pport_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [1:0]    nsync,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic [DW-1:0] mask,
  output logic          s_ready,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          fs3_out
);

  logic take;
  assign s_ready = active;
  assign take    = active && s_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_out  <= '0;
      pd_oe   <= 1'b0;
      fs3_out <= 1'b0;
    end else begin
      pd_oe   <= active;
      fs3_out <= take && (nsync == 2'd3);
      if (take) pd_out <= s_data & mask;
    end
  end

  p_oe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> pd_oe);
  p_tx_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> ((pd_out & ~$past(mask)) == '0));
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && s_valid) |=> $stable(pd_out));

endmodule

// File: rtl/pport_engine.sv
module pport_engine
  import pport_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        cfg_mode,
  input  logic [4:0]        cfg_width,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic [1:0]        cfg_nsync,
  input  logic              fs1_in,
  output logic              fs1_out,
  output logic              fs2_out,
  output logic              fs3_out,
  input  logic [DW-1:0]     pd_in,
  output logic [DW-1:0]     pd_out,
  output logic              pd_oe,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DW-1:0]     m_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DW-1:0]     s_data,
  output logic              err_sync,
  output logic              err_ovf
);

  mode_e         mode;
  logic [31:0]   mask32;
  logic [DW-1:0] mask;
  logic          data_phase, adv, rx_sample, tx_active;

  assign mode      = mode_e'(cfg_mode);
  assign mask32    = width_mask(cfg_width);
  assign mask      = mask32[DW-1:0];
  assign adv       = (mode == MODE_OUT) ? s_valid : 1'b1;
  assign rx_sample = data_phase && ((mode == MODE_IN) || (mode == MODE_FCAP));
  assign tx_active = data_phase && (mode == MODE_OUT);

  pport_seq #(.DLY_W(DLY_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) u_seq (
    .clk, .rst_n, .en, .mode, .nsync(cfg_nsync), .fs1_in,
    .cfg_delay, .cfg_count, .cfg_lines, .adv,
    .data_phase, .fs1_out, .fs2_out, .sync_err(err_sync)
  );

  pport_rx #(.DW(DW)) u_rx (
    .clk, .rst_n, .sample(rx_sample), .pd_in, .mask, .m_ready,
    .m_valid, .m_data, .ovf(err_ovf)
  );

  pport_tx #(.DW(DW)) u_tx (
    .clk, .rst_n, .active(tx_active), .nsync(cfg_nsync), .s_valid, .s_data,
    .mask, .s_ready, .pd_out, .pd_oe, .fs3_out
  );

  p_oe_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd3 && $past(cfg_mode) != 2'd3) |-> !pd_oe);
  p_half_duplex_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && rx_sample));

endmodule

// File: tb/pport_engine_tb.sv
module pport_engine_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, en, fs1_in, m_ready, s_valid;
  logic [1:0] cfg_mode, cfg_nsync;
  logic [4:0] cfg_width;
  logic [7:0] cfg_delay;
  logic [11:0] cfg_count;
  logic [9:0] cfg_lines;
  logic [15:0] pd_in, s_data;
  logic fs1_out, fs2_out, fs3_out, pd_oe, m_valid, s_ready, err_sync, err_ovf;
  logic [15:0] pd_out, m_data;

  int total = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  pport_engine u_dut (
    .clk, .rst_n, .en, .cfg_mode, .cfg_width, .cfg_delay, .cfg_count,
    .cfg_lines, .cfg_nsync, .fs1_in, .fs1_out, .fs2_out, .fs3_out,
    .pd_in, .pd_out, .pd_oe, .m_valid, .m_ready, .m_data,
    .s_valid, .s_ready, .s_data, .err_sync, .err_ovf
  );

  function automatic logic [15:0] pat(int n);
    logic [31:0] p;
    p = n * 32'h1357;
    return p[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] emask(int w);
    int e;
    e = (w == 8) ? 8 : ((w >= 10 && w <= 16) ? w : 16);
    return 16'((32'h1 << e) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; fs1_in = 1'b0; m_ready = 1'b1; s_valid = 1'b0;
    cfg_mode = 2'd0; cfg_nsync = 2'd0; cfg_width = 5'd16; cfg_delay = '0;
    cfg_count = 12'd1; cfg_lines = 10'd1; pd_in = '0; s_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 m_valid", m_valid, 0);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 pd_oe", pd_oe, 0);
    chk("R1 syncs", {fs1_out, fs2_out, fs3_out}, 0);
    chk("R1 errors", {err_sync, err_ovf}, 0);
  endtask

  // Input mode capture; sec>0 adds a second sync edge at that iteration (R9).
  task automatic t_capture(int d, int c, int w, int sec);
    int got = 0;
    int bad = 0;
    int ec;
    do_reset();
    ec = (c == 0) ? 1 : c;
    cfg_mode = 2'd1; cfg_delay = 8'(d); cfg_count = 12'(c);
    cfg_width = 5'(w); en = 1'b1;
    for (int it = 0; it < d + c + 10; it++) begin
      @(negedge clk);
      if (m_valid) begin
        if (got < ec)
          chk($sformatf("R2/R4 sample %0d", got), m_data, pat(1 + d + got) & emask(w));
        got++;
      end
      if (pd_oe || fs1_out || fs2_out || fs3_out) bad++;
      fs1_in = (it == 0) || (sec > 0 && it == sec);
      pd_in = pat(it);
    end
    fs1_in = 1'b0;
    chk("R3 sample count", got, ec);
    chk("R8 no drive in input mode", bad, 0);
    chk("R9 sync error flag", err_sync, (sec > 0) ? 1 : 0);
  endtask

  task automatic t_fcap();
    int got = 0;
    int np = 0;
    int bad = 0;
    int k;
    do_reset();
    cfg_mode = 2'd2; cfg_delay = 8'd1; cfg_count = 12'd2; cfg_lines = 10'd3;
    for (int it = 0; it < 26; it++) begin
      @(negedge clk);
      if (fs1_out) begin
        if (np < 6) begin
          chk("R5 line start spacing", it, 1 + 4 * np);
          chk("R5 frame sync", fs2_out, (np % 3 == 0) ? 1 : 0);
        end
        np++;
      end else if (fs2_out) bad++;
      if (pd_oe || s_ready || fs3_out) bad++;
      if (m_valid) begin
        if (got < 12) begin
          k = got / 2;
          chk("R5 sampled data", m_data, pat(1 + 4 * k + 1 + got % 2));
        end
        got++;
      end
      en = (it < 25);
      pd_in = pat(it);
    end
    en = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 pulse count", (np >= 6) ? 1 : 0, 1);
    chk("R8 no drive in frame capture", bad, 0);
  endtask

  task automatic t_output(int d, int c, int ns, int w);
    int acc = 0;
    int n3 = 0;
    int n1 = 0;
    int n2 = 0;
    int oebad = 0;
    logic prev_rdy = 1'b0;
    do_reset();
    cfg_mode = 2'd3; cfg_delay = 8'(d); cfg_count = 12'(c);
    cfg_nsync = 2'(ns); cfg_width = 5'(w); cfg_lines = 10'd2;
    for (int it = 0; it < 3 * c + d + 12; it++) begin
      @(negedge clk);
      if (pd_oe !== prev_rdy) oebad++;
      if (fs1_out) n1++;
      if (fs2_out) n2++;
      if (fs3_out) begin
        chk("R6 word on bus", pd_out, pat(100 + n3) & emask(w));
        chk("R8 drive with strobe", pd_oe, 1);
        n3++;
      end
      en = (it == 0);
      s_valid = (it % 3 != 2) && (acc < c + 2);
      s_data = pat(100 + acc);
      prev_rdy = s_ready;
      if (s_valid && s_ready) acc++;
    end
    s_valid = 1'b0;
    chk("R6 words accepted", acc, c);
    chk("R6 last word held", pd_out, pat(100 + c - 1) & emask(w));
    chk("R7 fs1 pulses", n1, (ns >= 1) ? 1 : 0);
    chk("R7 fs2 pulses", n2, (ns >= 2) ? 1 : 0);
    chk("R7 fs3 pulses", n3, (ns == 3) ? c : 0);
    chk("R8 drive enable timing", oebad, 0);
    chk("R8 released after burst", pd_oe, 0);
  endtask

  task automatic t_overrun();
    logic [15:0] first;
    do_reset();
    cfg_mode = 2'd1; cfg_delay = '0; cfg_count = 12'd3; en = 1'b1;
    m_ready = 1'b0;
    for (int it = 0; it < 8; it++) begin
      @(negedge clk);
      fs1_in = (it == 0);
      pd_in = pat(it);
    end
    first = pat(1);
    chk("R10 held word valid", m_valid, 1);
    chk("R10 first word kept", m_data, first);
    chk("R10 overrun flag", err_ovf, 1);
    m_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", m_valid, 0);
    chk("R10 flag sticky", err_ovf, 1);
  endtask

  task automatic t_enable();
    int seen = 0;
    do_reset();
    cfg_mode = 2'd1; en = 1'b0;
    for (int it = 0; it < 8; it++) begin
      @(negedge clk);
      if (m_valid) seen++;
      fs1_in = (it == 1);
    end
    chk("R11 no capture with en low", seen, 0);
    cfg_mode = 2'd0; en = 1'b1; seen = 0;
    for (int it = 0; it < 8; it++) begin
      @(negedge clk);
      if (m_valid || s_ready || fs1_out || pd_oe) seen++;
      fs1_in = (it == 1);
    end
    chk("R11 mode off stays idle", seen, 0);
  endtask

  initial begin
    t_reset();
    t_capture(2, 5, 16, 0);
    t_capture(0, 4, 8, 0);
    t_capture(1, 3, 12, 0);
    t_capture(3, 2, 9, 0);
    t_capture(0, 0, 16, 0);
    t_capture(3, 4, 16, 2);
    t_fcap();
    t_output(0, 4, 3, 10);
    t_output(2, 3, 1, 16);
    t_output(1, 2, 2, 8);
    t_overrun();
    t_enable();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule